// File: doc/BRIEF.md
# Lazy Condition-Code Flag Evaluator

This block rebuilds the four integer condition flags (negative, zero, overflow, carry) after the fact, from three saved items: an operation tag, the source operand and the result word. The core that uses it does not compute flags on every arithmetic step. It only records what happened, and asks for the flags when a later instruction needs them. A capture strobe loads the tag and both words. An evaluate strobe turns them into a registered 4-bit flag vector. Evaluation also rewrites the saved state into pass-through form, so asking again returns the same flags.

A second port runs multi-word extended add and subtract. The block holds its own extend bit. A set extend bit makes the step add or subtract one extra unit. The step's carry condition becomes the new extend bit. The zero flag only survives while every word of the chain was zero. A start-of-chain input treats the extend bit as clear and the earlier zero flag as set.

Top module: `ccflag_eval`

## Requirements
- R1: The flag vector is N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Tag 0 (pass-through) returns the low four bits of the saved result word as the flags.
- R2: Tag 1 (logic) sets Z when the result is zero, or else N when result bit 31 is set. V and C are zero.
- R3: Tag 2 (add) treats the saved words as result = x + src. It reports the carry out of that 32-bit addition, signed overflow, and N and Z of the result.
- R4: Tag 3 (subtract) treats the saved words as result = x − src. C is the borrow (x unsigned-less-than src) and V is signed subtract overflow. N and Z come from the result.
- R5: Tag 4 (byte compare) and tag 5 (word compare) apply the subtract rule to only the low 8 or 16 bits of both words. All four flags are taken at bit 7 or bit 15, and the upper bits are ignored.
- R6: Tag 6 (extended add) treats the saved words as result = x + src + 1. Tag 7 (extended subtract) treats them as result = x − src − 1. Carry and overflow cover the extra unit.
- R7: Tag 8 (shift) sets N and Z from the result, and sets C when the saved source word is nonzero. V is zero.
- R8: A chain step computes a + b + X (add) or a − b − X (subtract) and registers the result. It sets the flags by the extended or plain rule. It copies the new C into the extend output, and ANDs Z with the previous Z. A start-of-chain step uses X = 0 and a previous Z of 1.
- R9: Tags 9 to 15 are illegal. Evaluating one clears all flags and raises the error output for exactly one cycle.
- R10: Flags update on the clock edge that samples the evaluate strobe. The saved tag then becomes pass-through, so a repeated evaluation leaves the flags unchanged.
- R11: Priority is chain step, then capture, then evaluate. An evaluate strobe together with a capture or a chain step is ignored. Reset clears the flags, the extend bit, the chain result and the error output, and leaves the saved tag at pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Load tag, source and result |
| cap_kind | input | 4 | Operation tag to save |
| cap_src | input | 32 | Source operand to save |
| cap_dst | input | 32 | Result word to save |
| eval_req | input | 1 | Build flags from the saved state |
| chain_valid | input | 1 | Run one extended add/subtract step |
| chain_sub | input | 1 | 1 = subtract step, 0 = add step |
| chain_first | input | 1 | First (least significant) word of a chain |
| chain_a | input | 32 | Chain first operand |
| chain_b | input | 32 | Chain second operand |
| flags | output | 4 | Registered {N,Z,V,C} |
| xflag | output | 1 | Registered extend bit |
| chain_res | output | 32 | Registered chain step result |
| bad_kind | output | 1 | One-cycle pulse for an illegal tag |

## Verification
Some properties are checked by assertion on every cycle: the error pulse lasts one cycle and always comes with cleared flags, the extend bit follows carry after a chain step, a cleared Z stays cleared through later chain words, and back-to-back evaluations keep the flags steady. The flag arithmetic for each tag can only be shown by the bench scenarios. There, the expected carry, borrow and overflow come from wide-integer reference sums of the original operands. The same holds for the 64-bit add and subtract carried through two chained words, and for the ordering between capture, evaluate and chain steps.

// File: rtl/ccflag_eval.sv
module ccflag_eval #(
  parameter int W  = 32,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  input  logic [KW-1:0] cap_kind,
  input  logic [W-1:0]  cap_src,
  input  logic [W-1:0]  cap_dst,
  input  logic          eval_req,
  input  logic          chain_valid,
  input  logic          chain_sub,
  input  logic          chain_first,
  input  logic [W-1:0]  chain_a,
  input  logic [W-1:0]  chain_b,
  output logic [3:0]    flags,
  output logic          xflag,
  output logic [W-1:0]  chain_res,
  output logic          bad_kind
);

  localparam logic [KW-1:0] K_PASS  = KW'(0);
  localparam logic [KW-1:0] K_LOGIC = KW'(1);
  localparam logic [KW-1:0] K_ADD   = KW'(2);
  localparam logic [KW-1:0] K_SUB   = KW'(3);
  localparam logic [KW-1:0] K_CMPB  = KW'(4);
  localparam logic [KW-1:0] K_CMPW  = KW'(5);
  localparam logic [KW-1:0] K_ADDX  = KW'(6);
  localparam logic [KW-1:0] K_SUBX  = KW'(7);
  localparam logic [KW-1:0] K_SHIFT = KW'(8);
  localparam logic [W-1:0]  ONE     = W'(1);

  logic [KW-1:0] kind_q;
  logic [W-1:0]  src_q, dst_q;
  logic          ev_go, ev_go_q, ev_bad;
  logic [3:0]    ev_flags, ch_raw, ch_flags;
  logic          ch_x, ch_zprev;
  logic [W-1:0]  ch_sum;
  logic [KW-1:0] ch_kind;

  function automatic logic [3:0] nz_of(input logic [W-1:0] r);
    return {r[W-1] & (r != '0), r == '0, 2'b00};
  endfunction

  function automatic logic [3:0] calc(input logic [KW-1:0] k,
                                      input logic [W-1:0] s,
                                      input logic [W-1:0] d);
    logic [3:0]   f;
    logic [W-1:0] t;
    f = 4'b0000;
    t = '0;
    case (k)
      K_PASS:  f = d[3:0];
      K_LOGIC: f = nz_of(d);
      K_ADD: begin
        f = nz_of(d);
        t = d - s;
        f[0] = d < s;
        f[1] = ((s[W-1] ^ d[W-1]) & ~(t[W-1] ^ s[W-1]));
      end
      K_ADDX: begin
        f = nz_of(d);
        t = d - s - ONE;
        f[0] = d <= s;
        f[1] = ((s[W-1] ^ d[W-1]) & ~(t[W-1] ^ s[W-1]));
      end
      K_SUB: begin
        f = nz_of(d);
        t = d + s;
        f[0] = t < s;
        f[1] = (t[W-1] ^ d[W-1]) & (t[W-1] ^ s[W-1]);
      end
      K_SUBX: begin
        f = nz_of(d);
        t = d + s + ONE;
        f[0] = t <= s;
        f[1] = (t[W-1] ^ d[W-1]) & (t[W-1] ^ s[W-1]);
      end
      K_CMPB: begin
        t = d + s;
        f[3] = d[7];
        f[2] = d[7:0] == 8'h00;
        f[0] = t[7:0] < s[7:0];
        f[1] = (t[7] ^ d[7]) & (t[7] ^ s[7]);
      end
      K_CMPW: begin
        t = d + s;
        f[3] = d[15];
        f[2] = d[15:0] == 16'h0000;
        f[0] = t[15:0] < s[15:0];
        f[1] = (t[15] ^ d[15]) & (t[15] ^ s[15]);
      end
      K_SHIFT: begin
        f = nz_of(d);
        f[0] = s != '0;
      end
      default: f = 4'b0000;
    endcase
    return f;
  endfunction

  assign ev_go    = eval_req & ~cap_valid & ~chain_valid;
  assign ev_bad   = kind_q > K_SHIFT;
  assign ev_flags = calc(kind_q, src_q, dst_q);

  assign ch_x     = chain_first ? 1'b0 : xflag;
  assign ch_zprev = chain_first ? 1'b1 : flags[2];
  assign ch_sum   = chain_sub ? chain_a - chain_b - {{(W-1){1'b0}}, ch_x}
                              : chain_a + chain_b + {{(W-1){1'b0}}, ch_x};
  assign ch_kind  = chain_sub ? (ch_x ? K_SUBX : K_SUB) : (ch_x ? K_ADDX : K_ADD);
  assign ch_raw   = calc(ch_kind, chain_b, ch_sum);
  assign ch_flags = {ch_raw[3], ch_raw[2] & ch_zprev, ch_raw[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q    <= K_PASS;
      src_q     <= '0;
      dst_q     <= '0;
      flags     <= 4'b0000;
      xflag     <= 1'b0;
      chain_res <= '0;
      bad_kind  <= 1'b0;
      ev_go_q   <= 1'b0;
    end else begin
      bad_kind <= 1'b0;
      ev_go_q  <= ev_go;
      if (chain_valid) begin
        flags     <= ch_flags;
        xflag     <= ch_flags[0];
        chain_res <= ch_sum;
        kind_q    <= K_PASS;
        src_q     <= '0;
        dst_q     <= {{(W-4){1'b0}}, ch_flags};
      end else if (cap_valid) begin
        kind_q <= cap_kind;
        src_q  <= cap_src;
        dst_q  <= cap_dst;
      end else if (eval_req) begin
        flags    <= ev_bad ? 4'b0000 : ev_flags;
        bad_kind <= ev_bad;
        kind_q   <= K_PASS;
        src_q    <= '0;
        dst_q    <= {{(W-4){1'b0}}, (ev_bad ? 4'b0000 : ev_flags)};
      end
    end
  end

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kind |=> !bad_kind);
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_kind |-> flags == 4'b0000);
  p_idem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_go && ev_go_q) |=> $stable(flags));
  p_x_follows_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chain_valid |=> xflag == flags[0]);
  p_sticky_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_valid && !chain_first && !flags[2]) |=> !flags[2]);

endmodule

// File: tb/test_ccflag_eval.sv
`timescale 1ns/1ps
module test_ccflag_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 0, eval_req = 0, chain_valid = 0, chain_sub = 0, chain_first = 0;
  logic [3:0]  cap_kind = 0;
  logic [31:0] cap_src = 0, cap_dst = 0, chain_a = 0, chain_b = 0;
  logic [3:0]  flags;
  logic        xflag, bad_kind;
  logic [31:0] chain_res;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccflag_eval i_ccflag_eval (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_kind(cap_kind),
    .cap_src(cap_src), .cap_dst(cap_dst), .eval_req(eval_req),
    .chain_valid(chain_valid), .chain_sub(chain_sub), .chain_first(chain_first),
    .chain_a(chain_a), .chain_b(chain_b), .flags(flags), .xflag(xflag),
    .chain_res(chain_res), .bad_kind(bad_kind));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference flags {N,Z,V,C} from the original operands
  function automatic logic [3:0] r_add(input logic [31:0] a, b, input logic ci);
    logic [32:0] s = {1'b0, a} + {1'b0, b} + {32'd0, ci};
    return {s[31], s[31:0] == 0, (a[31] == b[31]) && (s[31] != a[31]), s[32]};
  endfunction
  function automatic logic [3:0] r_sub(input logic [31:0] a, b, input logic bi);
    logic [32:0] s = {1'b0, a} - {1'b0, b} - {32'd0, bi};
    return {s[31], s[31:0] == 0, (a[31] != b[31]) && (s[31] != a[31]), s[32]};
  endfunction
  function automatic logic [3:0] r_cmp(input logic [15:0] a, b, input bit word);
    int sa = word ? int'($signed(a)) : int'($signed(a[7:0]));
    int sb = word ? int'($signed(b)) : int'($signed(b[7:0]));
    int d = sa - sb;
    int lim = word ? 32768 : 128;
    logic [15:0] r = a - b;
    logic n = word ? r[15] : r[7];
    logic z = word ? (r == 0) : (r[7:0] == 0);
    logic c = word ? (a < b) : (a[7:0] < b[7:0]);
    return {n, z, (d >= lim) || (d < -lim), c};
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic eval_case(input logic [3:0] k, input logic [31:0] s, d,
                           input logic [3:0] exp, input string req);
    cap_valid = 1; cap_kind = k; cap_src = s; cap_dst = d;
    tick(); cap_valid = 0; eval_req = 1;
    tick(); eval_req = 0;
    check(req, {60'd0, flags}, {60'd0, exp});
    check(req, {63'd0, bad_kind}, 64'd0);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 6))
      0: return 32'h0;
      1: return 32'h7fffffff;
      2: return 32'h80000000;
      3: return 32'hffffffff;
      default: return $urandom();
    endcase
  endfunction

  task automatic chain64(input bit sub, input logic [63:0] A, B);
    logic [64:0] S;
    logic [3:0]  e;
    logic [31:0] lo, hi;
    chain_valid = 1; chain_sub = sub; chain_first = 1; chain_a = A[31:0]; chain_b = B[31:0];
    tick(); lo = chain_res;
    chain_first = 0; chain_a = A[63:32]; chain_b = B[63:32];
    tick(); hi = chain_res; chain_valid = 0;
    S = sub ? ({1'b0, A} - {1'b0, B}) : ({1'b0, A} + {1'b0, B});
    e[3] = S[63]; e[2] = S[63:0] == 0; e[0] = S[64];
    e[1] = sub ? ((A[63] != B[63]) && (S[63] != A[63])) : ((A[63] == B[63]) && (S[63] != A[63]));
    check("R8 result", {hi, lo}, S[63:0]);
    check("R8 flags", {60'd0, flags}, {60'd0, e});
    check("R8 extend", {63'd0, xflag}, {63'd0, e[0]});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, d;
    logic [3:0]  hold;
    void'($urandom(32'd2024));
    tick(); tick(); rst_n = 1; tick();
    // R11 reset state
    check("R11 reset flags", {60'd0, flags}, 64'd0);
    check("R11 reset x/err", {62'd0, xflag, bad_kind}, 64'd0);
    check("R11 reset res", {32'd0, chain_res}, 64'd0);
    // R1 pass-through
    eval_case(4'd0, 32'h0, 32'hABCD_0009, 4'b1001, "R1 pass");
    // R2 logic corners
    eval_case(4'd1, 32'h5, 32'h0, 4'b0100, "R2 zero");
    eval_case(4'd1, 32'h5, 32'h8000_0000, 4'b1000, "R2 neg");
    // R3 add overflow corner
    eval_case(4'd2, 32'h1, 32'h8000_0000, r_add(32'h7fffffff, 32'h1, 0), "R3 ovf");
    // R4 subtract borrow
    eval_case(4'd4, 32'hFFFF_FF01, 32'h1234_567F, r_cmp(16'h0080, 16'h0001, 0), "R5 byte ovf");
    eval_case(4'd3, 32'h1, 32'hffffffff, r_sub(32'h0, 32'h1, 0), "R4 borrow");
    // R6 extended with the extra unit
    eval_case(4'd6, 32'hffffffff, 32'h0, r_add(32'h0, 32'hffffffff, 1), "R6 addx");
    eval_case(4'd7, 32'h0, 32'hffffffff, r_sub(32'h0, 32'h0, 1), "R6 subx");
    // R7 shift
    eval_case(4'd8, 32'h1, 32'h0, 4'b0101, "R7 shift c");
    // R10 re-evaluation and tag switch
    eval_case(4'd2, 32'h1, 32'h0, r_add(32'hffffffff, 32'h1, 0), "R10 first");
    hold = flags;
    eval_req = 1; tick(); tick(); eval_req = 0;
    check("R10 idempotent", {60'd0, flags}, {60'd0, hold});
    // R9 illegal tag
    cap_valid = 1; cap_kind = 4'd12; tick(); cap_valid = 0; eval_req = 1; tick(); eval_req = 0;
    check("R9 err", {59'd0, bad_kind, flags}, {59'd0, 1'b1, 4'b0000});
    tick();
    check("R9 pulse", {63'd0, bad_kind}, 64'd0);
    // R11 eval ignored alongside capture
    eval_case(4'd0, 32'h0, 32'h3, 4'b0011, "R11 setup");
    cap_valid = 1; eval_req = 1; cap_kind = 4'd1; cap_dst = 32'h0; tick();
    cap_valid = 0; eval_req = 0;
    check("R11 prio", {60'd0, flags}, 64'd3);
    eval_req = 1; tick(); eval_req = 0;
    check("R11 captured", {60'd0, flags}, 64'd4);
    // R8 directed: sticky zero with nonzero low word
    chain64(0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_0000_0000);
    chain64(0, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000);
    chain64(1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);
    chain64(1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 8);
      a = pick(); b = pick();
      case (k)
        0: eval_case(4'd0, b, a, a[3:0], "R1 rnd");
        1: eval_case(4'd1, b, a, {a[31] && a != 0, a == 0, 2'b00}, "R2 rnd");
        2: eval_case(4'd2, b, a + b, r_add(a, b, 0), "R3 rnd");
        3: eval_case(4'd3, b, a - b, r_sub(a, b, 0), "R4 rnd");
        4: begin d = {$urandom_range(0, 65535), 8'h00, a[7:0] - b[7:0]} ;
             eval_case(4'd4, {a[31:8], b[7:0]}, {d[31:8], a[7:0] - b[7:0]}, r_cmp({8'd0, a[7:0]}, {8'd0, b[7:0]}, 0), "R5 byte rnd"); end
        5: eval_case(4'd5, {a[31:16], b[15:0]}, {b[31:16], a[15:0] - b[15:0]}, r_cmp(a[15:0], b[15:0], 1), "R5 word rnd");
        6: eval_case(4'd6, b, a + b + 1, r_add(a, b, 1), "R6 addx rnd");
        7: eval_case(4'd7, b, a - b - 1, r_sub(a, b, 1), "R6 subx rnd");
        default: eval_case(4'd8, b & 32'h1, a, {a[31] && a != 0, a == 0, 1'b0, b[0]}, "R7 rnd");
      endcase
      if (i % 8 == 0) chain64(i[3], {pick(), pick()}, {pick(), pick()});
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule